// File: doc/BRIEF.md
# Station Address PROM Access Decoder

This block sits between a host bus and the register file of a network controller. It decodes single host accesses that arrive through one of two windows, an I/O window and a memory-mapped window. Each access either reaches a 16-byte station-address store or is handed on to an external register port. The decoder checks access size and alignment, and for the I/O window it also checks a run-time doubleword-mode bit. It gathers or scatters little-endian bytes across the store. A write-enable bit guards writes to the store. An access that matches no legal case reads back as all ones.

Each request is accepted in one cycle. The response, valid flag and read data, appears on the next cycle. Forwarded accesses show up on the register-port request lines in the same cycle as the host request. The register port must return its read data combinationally in that cycle. On reset the store takes a 48-bit station address in bytes 0 to 5 and zeros in bytes 6 to 15.

Top module: `sta_prom_decoder`

## Requirements
- R1: After reset, store byte i (i = 0..5) holds bits 8i+7:8i of the MAC_ADDR parameter, bytes 6 to 15 hold zero, and rsp_valid is low while reset is held.
- R2: Every request cycle (req_valid high) is followed on the next cycle by rsp_valid high. Cycles with no request are followed by rsp_valid low. For a write, rsp_rdata is zero.
- R3: Multi-byte store accesses are little-endian: the byte at the start index is on bits 7:0, the next index is on bits 15:8, and so on. Reads of 1 or 2 bytes return zero in the bits above the access width.
- R4: A store write changes nothing while cfg_prom_wr_en is low, and store reads still return the held data.
- R5: In the I/O window (req_window = 0), addresses 0x00 to 0x0F reach the store. With cfg_dword_mode low, only byte accesses (req_size = 0) at any address and 16-bit accesses (req_size = 1) at even addresses are legal.
- R6: With cfg_dword_mode high, the only legal store access in the I/O window is a 32-bit access (req_size = 2) at an address that is a multiple of 4.
- R7: An illegal access reads back all ones across the access width: 0xFF for size 0, 0xFFFF for size 1, and 0xFFFFFFFF for size 2 or for the reserved size code 3. An illegal write has no effect.
- R8: In the I/O window, addresses 0x10 and above are forwarded for sizes 1 and 2 with the full address as the offset. A byte access there is illegal.
- R9: In the memory window (req_window = 1), an address with bit 4 set forwards sizes 1 and 2 with offset equal to address bits 3:0. A byte access there is illegal.
- R10: In the memory window, an address with bit 4 clear reaches the store for sizes 0 to 2. There is no alignment or mode check. Bytes run from index address[3:0] upward and wrap from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dword_mode | input | 1 | I/O window doubleword mode |
| cfg_prom_wr_en | input | 1 | Store write enable |
| req_valid | input | 1 | Host request strobe |
| req_window | input | 1 | 0 = I/O window, 1 = memory window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| req_addr | input | ADDR_W | Byte address within the window |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rp_valid | output | 1 | Register-port request |
| rp_write | output | 1 | Register-port write flag |
| rp_size | output | 2 | Register-port size code |
| rp_offset | output | ADDR_W | Register-port offset |
| rp_wdata | output | 32 | Register-port write data |
| rp_rdata | input | 32 | Register-port read data, same cycle |

## Verification
The assertions assume the mode and write-enable bits stay fixed while a request is in flight. They also assume the register port answers in the same cycle. They take req_size, req_window and req_addr to be meaningful only while req_valid is high. The stimulus changes the configuration bits only between requests, on the falling edge, with req_valid low. It models the register port as a combinational function of the offset, which keeps every response inside those assumptions. Each of the four size codes is swept across every address in both windows and under both mode settings.

// File: rtl/sta_prom_pkg.sv
package sta_prom_pkg;

    localparam int PROM_BYTES = 16;
    localparam int IDX_W      = $clog2(PROM_BYTES);
    localparam int DATA_W     = 32;
    localparam int LANES      = DATA_W / 8;
    localparam int NB_W       = $clog2(LANES) + 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PROM = 2'd1,
        TGT_FWD  = 2'd2
    } acc_tgt_e;

    typedef struct packed {
        acc_tgt_e              tgt;
        logic [IDX_W-1:0]      base;
        logic [NB_W-1:0]       nbytes;
    } route_t;

    function automatic logic [DATA_W-1:0] width_mask(acc_size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [NB_W-1:0] byte_count(acc_size_e sz);
        case (sz)
            SZ_BYTE: return NB_W'(1);
            SZ_HALF: return NB_W'(2);
            SZ_WORD: return NB_W'(4);
            default: return NB_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/sta_prom_route.sv
module sta_prom_route
    import sta_prom_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              window,
    input  logic              dword_mode,
    input  acc_size_e         size,
    input  logic [ADDR_W-1:0] addr,
    output route_t            route,
    output logic [ADDR_W-1:0] fwd_offset
);

    localparam int HI_W = ADDR_W - IDX_W;

    logic legal_io;
    logic multi;

    assign multi = (size == SZ_HALF) || (size == SZ_WORD);

    always_comb begin
        if (!dword_mode)
            legal_io = (size == SZ_BYTE) || (size == SZ_HALF && !addr[0]);
        else
            legal_io = (size == SZ_WORD) && (addr[1:0] == 2'b00);
    end

    always_comb begin
        route.tgt    = TGT_NONE;
        route.base   = addr[IDX_W-1:0];
        route.nbytes = byte_count(size);
        fwd_offset   = addr;
        if (!window) begin
            if (addr[ADDR_W-1:IDX_W] == HI_W'(0)) begin
                if (legal_io)
                    route.tgt = TGT_PROM;
            end else if (multi) begin
                route.tgt = TGT_FWD;
            end
        end else begin
            if (addr[IDX_W]) begin
                fwd_offset = ADDR_W'(addr[IDX_W-1:0]);
                if (multi)
                    route.tgt = TGT_FWD;
            end else if (size != SZ_RSVD) begin
                route.tgt = TGT_PROM;
            end
        end
    end

endmodule

// File: rtl/sta_prom_bytes.sv
module sta_prom_bytes
    import sta_prom_pkg::*;
#(
    parameter logic [47:0] MAC_ADDR = 48'h0A1B_2C3D_4E5F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  base,
    input  logic [NB_W-1:0]   nbytes,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IMG_W = 8 * PROM_BYTES;
    localparam logic [IMG_W-1:0] INIT_IMAGE = IMG_W'(MAC_ADDR);

    logic [PROM_BYTES-1:0][7:0] mem;
    logic [LANES-1:0][IDX_W-1:0] lane_idx;
    logic [LANES-1:0]            lane_we;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_idx[k]      = base + IDX_W'(k);
        assign lane_we[k]       = wr_en && (NB_W'(k) < nbytes);
        assign rdata[8*k +: 8]  = mem[lane_idx[k]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= INIT_IMAGE;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_we[k])
                    mem[lane_idx[k]] <= wdata[8*k +: 8];
            end
        end
    end

    // R4
    store_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem));

    // R10
    store_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && nbytes == NB_W'(4) && base == IDX_W'(PROM_BYTES-1))
        |=> mem[0] == $past(wdata[15:8]));

    // R3
    store_low_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && nbytes != NB_W'(0)) |=> mem[$past(base)] == $past(wdata[7:0]));

endmodule

// File: rtl/sta_prom_decoder.sv
module sta_prom_decoder
    import sta_prom_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter logic [47:0] MAC_ADDR = 48'h0A1B_2C3D_4E5F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dword_mode,
    input  logic              cfg_prom_wr_en,
    input  logic              req_valid,
    input  logic              req_window,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rp_valid,
    output logic              rp_write,
    output logic [1:0]        rp_size,
    output logic [ADDR_W-1:0] rp_offset,
    output logic [31:0]       rp_wdata,
    input  logic [31:0]       rp_rdata
);

    acc_size_e         size_e;
    route_t            route;
    logic [ADDR_W-1:0] fwd_offset;
    logic              prom_we;
    logic [DATA_W-1:0] prom_rdata;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] read_val;

    assign size_e = acc_size_e'(req_size);
    assign mask   = width_mask(size_e);

    sta_prom_route #(.ADDR_W(ADDR_W)) u_route (
        .window     (req_window),
        .dword_mode (cfg_dword_mode),
        .size       (size_e),
        .addr       (req_addr),
        .route      (route),
        .fwd_offset (fwd_offset)
    );

    assign prom_we = req_valid && req_write && cfg_prom_wr_en && (route.tgt == TGT_PROM);

    sta_prom_bytes #(.MAC_ADDR(MAC_ADDR)) u_bytes (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (prom_we),
        .base   (route.base),
        .nbytes (route.nbytes),
        .wdata  (req_wdata),
        .rdata  (prom_rdata)
    );

    assign rp_valid  = req_valid && (route.tgt == TGT_FWD);
    assign rp_write  = req_write;
    assign rp_size   = req_size;
    assign rp_offset = fwd_offset;
    assign rp_wdata  = req_wdata;

    always_comb begin
        case (route.tgt)
            TGT_PROM: read_val = prom_rdata & mask;
            TGT_FWD:  read_val = rp_rdata & mask;
            default:  read_val = mask;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? read_val : '0;
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8
    fwd_no_byte_chk: assert property (@(posedge clk) disable iff (rst)
        rp_valid |-> (req_size == 2'd1 || req_size == 2'd2));

    // R7
    illegal_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && route.tgt == TGT_NONE)
        |=> rsp_rdata == width_mask(acc_size_e'($past(req_size))));

    // R6
    dword_prom_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_window && cfg_dword_mode && route.tgt == TGT_PROM)
        |-> (req_size == 2'd2 && req_addr[1:0] == 2'b00));

    // R9
    mem_fwd_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (rp_valid && req_window) |-> rp_offset[ADDR_W-1:IDX_W] == '0);

endmodule

// File: tb/test_sta_prom_decoder.sv
module test_sta_prom_decoder;

    localparam int          AW  = 5;
    localparam logic [47:0] MAC = 48'h0A1B_2C3D_4E5F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_dword_mode = 1'b0;
    logic          cfg_prom_wr_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_window = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rp_valid;
    logic          rp_write;
    logic [1:0]    rp_size;
    logic [AW-1:0] rp_offset;
    logic [31:0]   rp_wdata;
    logic [31:0]   rp_rdata;

    always #4 clk = ~clk;

    assign rp_rdata = 32'hBEEF_0000 | 32'(rp_offset);

    sta_prom_decoder #(.ADDR_W(AW), .MAC_ADDR(MAC)) i_sta_prom_decoder (
        .clk(clk), .rst(rst),
        .cfg_dword_mode(cfg_dword_mode), .cfg_prom_wr_en(cfg_prom_wr_en),
        .req_valid(req_valid), .req_window(req_window), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rp_valid(rp_valid), .rp_write(rp_write), .rp_size(rp_size),
        .rp_offset(rp_offset), .rp_wdata(rp_wdata), .rp_rdata(rp_rdata)
    );

    int nchk = 0;
    int nfail = 0;
    logic [7:0] m [16];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0 = illegal, 1 = store, 2 = forwarded
    function automatic int kind_of(bit win, bit dw, int sz, int a);
        if (sz == 3) return 0;
        if (!win) begin
            if (a < 16) begin
                if (!dw) return ((sz == 0) || (sz == 1 && a % 2 == 0)) ? 1 : 0;
                return (sz == 2 && a % 4 == 0) ? 1 : 0;
            end
            return (sz == 0) ? 0 : 2;
        end
        if (a >= 16) return (sz == 0) ? 0 : 2;
        return 1;
    endfunction

    task automatic access(input bit win, input bit wr, input int sz, input int a,
                          input logic [31:0] wd, input string force_tag);
        int k, nb, off;
        logic [31:0] mask, exp;
        string tag;
        k    = kind_of(win, cfg_dword_mode, sz, a);
        nb   = (sz < 3) ? (1 << sz) : 0;
        mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        off  = win ? (a % 16) : a;
        exp  = mask;
        if (k == 1) begin
            exp = 0;
            for (int j = 0; j < nb; j++) exp[8*j +: 8] = m[(a + j) % 16];
            if (!win) tag = cfg_dword_mode ? "R6" : "R5";
            else tag = ((a % 16) + nb > 16) ? "R10" : "R3";
        end else if (k == 2) begin
            exp = (32'hBEEF_0000 | 32'(off)) & mask;
            tag = win ? "R9" : "R8";
        end else begin
            tag = "R7";
        end
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        req_valid  = 1'b1;
        req_window = win;
        req_write  = wr;
        req_size   = 2'(sz);
        req_addr   = AW'(a);
        req_wdata  = wd;
        #1;
        if (k == 2) begin
            check(tag, {31'd0, rp_valid}, 32'd1);
            check(tag, 32'(rp_offset), 32'(off));
            check(tag, {30'd0, rp_size}, 32'(sz));
            check(tag, {31'd0, rp_write}, {31'd0, wr});
            if (wr) check(tag, rp_wdata, wd);
        end else begin
            check(tag, {31'd0, rp_valid}, 32'd0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", {31'd0, rsp_valid}, 32'd1);
        if (wr) check("R2", rsp_rdata, 32'd0);
        else check(tag, rsp_rdata, exp);
        if (wr && k == 1 && cfg_prom_wr_en)
            for (int j = 0; j < nb; j++) m[(a + j) % 16] = wd[8*j +: 8];
    endtask

    task automatic readback(input string tag);
        for (int i = 0; i < 16; i++) access(1'b1, 1'b0, 0, i, 32'd0, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 16; i++) m[i] = (i < 6) ? MAC[8*i +: 8] : 8'h00;
        repeat (3) @(negedge clk);
        check("R1", {31'd0, rsp_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {31'd0, rsp_valid}, 32'd0);
        readback("R1");
        access(1'b1, 1'b0, 2, 0, 32'd0, "R1");

        // writes while disabled, then reads of every combination
        cfg_prom_wr_en = 1'b0;
        for (int dw = 0; dw < 2; dw++) begin
            cfg_dword_mode = dw[0];
            for (int win = 0; win < 2; win++)
                for (int sz = 0; sz < 4; sz++)
                    for (int a = 0; a < 32; a++)
                        access(win[0], 1'b1, sz, a, 32'hC3A5_5A3C ^ 32'(a * 7 + sz), "");
        end
        readback("R4");
        for (int dw = 0; dw < 2; dw++) begin
            cfg_dword_mode = dw[0];
            for (int win = 0; win < 2; win++)
                for (int sz = 0; sz < 4; sz++)
                    for (int a = 0; a < 32; a++)
                        access(win[0], 1'b0, sz, a, 32'd0, "");
        end

        // enabled: write then read each combination
        cfg_prom_wr_en = 1'b1;
        for (int dw = 0; dw < 2; dw++) begin
            cfg_dword_mode = dw[0];
            for (int win = 0; win < 2; win++)
                for (int sz = 0; sz < 4; sz++)
                    for (int a = 0; a < 32; a++) begin
                        access(win[0], 1'b1, sz, a,
                               32'h9E37_79B9 * 32'(1 + a + 32 * sz + 128 * win + 256 * dw), "");
                        access(win[0], 1'b0, sz, a, 32'd0, "");
                    end
        end
        readback("R3");
        access(1'b1, 1'b1, 2, 14, 32'h4433_2211, "");
        access(1'b1, 1'b0, 2, 14, 32'd0, "R10");
        readback("R10");

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule